// File: doc/BRIEF.md
# Pre-Trigger Veto Sequencer

This block sits in a trigger path between the unit that issues triggers and a crate of digitiser boards. An early pre-trigger pulse warns the digitisers. They then compute one cluster bit per channel, and those bits are evaluated elsewhere. The evaluation comes back as a veto decision within a bounded latency. A fixed number of cycles after the pre-trigger, the real accept pulse arrives, and the sequencer drives a veto output aligned with that accept.

Every pre-trigger edge is entered into a delay line that is `LAT` slots deep, so each accept is paired with its own pre-trigger by position. A guard counter opens a dead window after each tracked pre-trigger. A pre-trigger inside that window is not forwarded and collects no veto decision. It still holds its slot, so its accept passes through with the veto low and no event is lost. Two sticky flags report problems: a decision strobe that misses its window or an event that never gets one, and an accept that arrives with no pending pre-trigger.

All counts are in cycles of the system clock. The defaults assume a 125 MHz clock: `LAT` = 300, a veto window from 60 to 80 cycles, and `DEAD` = 20.

Top module: `ptv_sequencer`

## Requirements
- R1: A rising edge on `accept_i` sampled at clock edge k gives `accept_o` high for exactly the one cycle that follows edge k.
- R2: A tracked pre-trigger (rising edge on `pretrig_i` at edge k) is forwarded as a one-cycle pulse on `pretrig_o` in the cycle after edge k.
- R3: A pre-trigger edge that comes 1 to `DEAD` cycles after the last tracked one is ignored: it is not forwarded, and its accept gives `veto_o` = 0. An edge more than `DEAD` cycles after the last tracked one is tracked.
- R4: `veto_o` goes high only together with `accept_o`, and only when three things hold: the accept edge came exactly `LAT` cycles after a tracked pre-trigger edge, the first `veto_stb_i` that arrived `VMIN` to `VMAX` cycles after that pre-trigger (both ends included) carried `veto_bit_i` = 1, and no reset came in between.
- R5: If that decision strobe carried `veto_bit_i` = 0, or if no strobe arrived inside the window, the accept passes with `veto_o` = 0.
- R6: `late_o` is set and stays set until reset in two cases: a `veto_stb_i` arrives while no tracked event is between `VMIN` and `VMAX` cycles old, or a tracked event gets older than `VMAX` cycles without a strobe.
- R7: An accept edge with no pre-trigger edge exactly `LAT` cycles before it sets `orphan_o`, which stays set until reset. The accept still appears on `accept_o` with `veto_o` = 0.
- R8: A pulse on `pretrig_i` or `accept_i` that is high for several cycles counts as one event.
- R9: Synchronous active-high `rst` clears all outputs, both flags, every pending event and the dead window. A pre-trigger edge right after reset is therefore tracked.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| pretrig_i | input | 1 | Pre-trigger pulse from the trigger source |
| veto_stb_i | input | 1 | One-cycle strobe: a veto decision is present |
| veto_bit_i | input | 1 | Veto decision, valid with the strobe |
| accept_i | input | 1 | Accept pulse from the trigger source |
| pretrig_o | output | 1 | Forwarded pre-trigger to the digitisers |
| accept_o | output | 1 | Forwarded accept pulse |
| veto_o | output | 1 | Veto aligned with `accept_o` |
| late_o | output | 1 | Sticky flag: decision missing or outside its window |
| orphan_o | output | 1 | Sticky flag: accept with no pending pre-trigger |

## Verification
The hardest state to reach from the ports is a reset that lands while events are still in flight and the dead window is still open. Without it, the bench could not show that pending entries are discarded rather than delayed, or that the guard really restarts. The stimulus tracks one pre-trigger, tracks a second ninety cycles later, and resets ten cycles after that. It then sends a pre-trigger that the old dead window would have dropped, plus an accept lined up with the first, discarded event. Together these show that the flags were cleared, that the guard restarted, and that the stale slot is gone.

// File: rtl/ptv_pkg.sv
package ptv_pkg;

    // one slot of the event delay line
    typedef struct packed {
        logic valid;   // a pre-trigger edge occupies this slot
        logic track;   // pre-trigger was outside the dead window
        logic done;    // a veto decision has been attached
        logic veto;    // attached veto decision
    } slot_t;

endpackage

// File: rtl/ptv_edge.sv
module ptv_edge (
    input  logic clk,
    input  logic rst,
    input  logic level_i,
    output logic rise_o
);
    typedef struct packed {
        logic prev;
    } state_t;

    state_t s_d, s_q;

    always_comb begin
        s_d      = s_q;
        s_d.prev = level_i;
        rise_o   = level_i & ~s_q.prev;
    end

    always_ff @(posedge clk) begin
        if (rst) s_q <= '0;
        else     s_q <= s_d;
    end
endmodule

// File: rtl/ptv_guard.sv
module ptv_guard #(
    parameter int DEAD = 20
) (
    input  logic clk,
    input  logic rst,
    input  logic rise_i,
    output logic take_o
);
    localparam int CW = $clog2(DEAD + 1);

    typedef struct packed {
        logic [CW-1:0] left;
    } state_t;

    state_t s_d, s_q;

    always_comb begin
        s_d    = s_q;
        take_o = rise_i && (s_q.left == '0);
        if (take_o)
            s_d.left = CW'(DEAD);
        else if (s_q.left != '0)
            s_d.left = s_q.left - 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) s_q <= '0;
        else     s_q <= s_d;
    end
endmodule

// File: rtl/ptv_line.sv
module ptv_line
    import ptv_pkg::*;
#(
    parameter int LAT  = 300,
    parameter int VMIN = 60,
    parameter int VMAX = 80
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  push_i,
    input  logic  track_i,
    input  logic  stb_i,
    input  logic  bit_i,
    output slot_t head_o,
    output logic  win_hit_o,
    output logic  expire_o
);
    // slot k holds an event that is k+1 cycles old when the next edge samples it
    localparam int WLO = VMIN - 1;
    localparam int WHI = VMAX - 1;

    typedef struct packed {
        slot_t [LAT-1:0] slot;
    } state_t;

    state_t s_d, s_q;

    always_comb begin
        slot_t cur;
        s_d       = s_q;
        win_hit_o = 1'b0;
        for (int i = WLO; i <= WHI; i++)
            if (s_q.slot[i].valid && s_q.slot[i].track)
                win_hit_o = 1'b1;
        for (int i = 0; i < LAT - 1; i++) begin
            cur = s_q.slot[i];
            if (i >= WLO && i <= WHI && stb_i && cur.valid && cur.track && !cur.done) begin
                cur.done = 1'b1;
                cur.veto = bit_i;
            end
            s_d.slot[i+1] = cur;
        end
        s_d.slot[0] = push_i ? slot_t'{valid: 1'b1, track: track_i, done: 1'b0, veto: 1'b0}
                             : slot_t'('0);
        head_o   = s_q.slot[LAT-1];
        expire_o = s_q.slot[VMAX].valid && s_q.slot[VMAX].track && !s_q.slot[VMAX].done;
    end

    always_ff @(posedge clk) begin
        if (rst) s_q <= '0;
        else     s_q <= s_d;
    end
endmodule

// File: rtl/ptv_sequencer.sv
module ptv_sequencer
    import ptv_pkg::*;
#(
    parameter int LAT  = 300,
    parameter int VMIN = 60,
    parameter int VMAX = 80,
    parameter int DEAD = 20
) (
    input  logic clk,
    input  logic rst,
    input  logic pretrig_i,
    input  logic veto_stb_i,
    input  logic veto_bit_i,
    input  logic accept_i,
    output logic pretrig_o,
    output logic accept_o,
    output logic veto_o,
    output logic late_o,
    output logic orphan_o
);
    localparam int NPULSE = 2;

    typedef struct packed {
        logic pre;
        logic acc;
        logic veto;
        logic late;
        logic orphan;
    } state_t;

    state_t s_d, s_q;

    logic [NPULSE-1:0] raw, rise;
    logic  take, win_hit, expire;
    slot_t head;

    assign raw = {accept_i, pretrig_i};

    for (genvar g = 0; g < NPULSE; g++) begin : g_edge
        ptv_edge u_edge (
            .clk     (clk),
            .rst     (rst),
            .level_i (raw[g]),
            .rise_o  (rise[g])
        );
    end

    ptv_guard #(.DEAD(DEAD)) u_guard (
        .clk    (clk),
        .rst    (rst),
        .rise_i (rise[0]),
        .take_o (take)
    );

    ptv_line #(.LAT(LAT), .VMIN(VMIN), .VMAX(VMAX)) u_line (
        .clk       (clk),
        .rst       (rst),
        .push_i    (rise[0]),
        .track_i   (take),
        .stb_i     (veto_stb_i),
        .bit_i     (veto_bit_i),
        .head_o    (head),
        .win_hit_o (win_hit),
        .expire_o  (expire)
    );

    always_comb begin
        s_d        = s_q;
        s_d.pre    = take;
        s_d.acc    = rise[1];
        s_d.veto   = rise[1] & head.valid & head.track & head.done & head.veto;
        s_d.orphan = s_q.orphan | (rise[1] & ~head.valid);
        s_d.late   = s_q.late | expire | (veto_stb_i & ~win_hit);
    end

    always_ff @(posedge clk) begin
        if (rst) s_q <= '0;
        else     s_q <= s_d;
    end

    assign pretrig_o = s_q.pre;
    assign accept_o  = s_q.acc;
    assign veto_o    = s_q.veto;
    assign late_o    = s_q.late;
    assign orphan_o  = s_q.orphan;
endmodule

// File: rtl/ptv_sequencer_chk.sv
module ptv_sequencer_chk #(
    parameter int DEAD = 20
) (
    input logic clk,
    input logic rst,
    input logic accept_i,
    input logic pretrig_o,
    input logic accept_o,
    input logic veto_o,
    input logic late_o,
    input logic orphan_o
);
    localparam int GW = $clog2(DEAD + 2) + 1;

    // cycles since the last forwarded pre-trigger, saturating
    logic [GW-1:0] gap_q;
    always_ff @(posedge clk) begin
        if (rst)                      gap_q <= GW'(DEAD + 1);
        else if (pretrig_o)           gap_q <= GW'(1);
        else if (gap_q <= GW'(DEAD))  gap_q <= gap_q + 1'b1;
    end

    a_r1_accept_passes: assert property (@(posedge clk) disable iff (rst)
        $rose(accept_i) |=> accept_o);

    a_r1_accept_single: assert property (@(posedge clk) disable iff (rst)
        accept_o |=> !accept_o);

    a_r3_fwd_spacing: assert property (@(posedge clk) disable iff (rst)
        pretrig_o |-> (gap_q > GW'(DEAD)));

    a_r4_veto_with_accept: assert property (@(posedge clk) disable iff (rst)
        veto_o |-> accept_o);

    a_r6_late_sticky: assert property (@(posedge clk) disable iff (rst)
        late_o |=> late_o);

    a_r7_orphan_sticky: assert property (@(posedge clk) disable iff (rst)
        orphan_o |=> orphan_o);
endmodule

bind ptv_sequencer ptv_sequencer_chk #(.DEAD(DEAD)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .accept_i  (accept_i),
    .pretrig_o (pretrig_o),
    .accept_o  (accept_o),
    .veto_o    (veto_o),
    .late_o    (late_o),
    .orphan_o  (orphan_o)
);

// File: tb/test_ptv_sequencer.sv
module test_ptv_sequencer;
    localparam int LAT  = 300;
    localparam int VMIN = 60;
    localparam int VMAX = 80;
    localparam int DEAD = 20;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic pretrig_i = 1'b0, veto_stb_i = 1'b0, veto_bit_i = 1'b0, accept_i = 1'b0;
    logic pretrig_o, accept_o, veto_o, late_o, orphan_o;

    always #2 clk = ~clk;

    ptv_sequencer #(.LAT(LAT), .VMIN(VMIN), .VMAX(VMAX), .DEAD(DEAD)) i_ptv_sequencer (
        .clk(clk), .rst(rst), .pretrig_i(pretrig_i), .veto_stb_i(veto_stb_i),
        .veto_bit_i(veto_bit_i), .accept_i(accept_i), .pretrig_o(pretrig_o),
        .accept_o(accept_o), .veto_o(veto_o), .late_o(late_o), .orphan_o(orphan_o));

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    bit sch_pre[int], sch_acc[int], sch_stb[int], sch_bit[int], sch_rst[int];
    int exp_t[$];
    bit exp_v[$];
    int n_cmp = 0, n_bad = 0, fwd_exp = 0, fwd_seen = 0, last_trk = -1000;
    bit finished = 0;

    // driver: inputs for the coming edge cyc+1
    always @(negedge clk) begin
        rst        = sch_rst.exists(cyc + 1);
        pretrig_i  = sch_pre.exists(cyc + 1);
        accept_i   = sch_acc.exists(cyc + 1);
        veto_stb_i = sch_stb.exists(cyc + 1);
        veto_bit_i = sch_bit.exists(cyc + 1);
    end

    task automatic check(input string req, input logic act, input logic expv);
        n_cmp++;
        if (act !== expv) begin
            n_bad++;
            $display("FAIL %s cyc=%0d actual=%b expected=%b", req, cyc, act, expv);
        end
    endtask

    // pre-trigger at edge t; vlat < 0 means no decision strobe
    task automatic add_evt(input int t, input int pw, input int aw, input int vlat, input bit vbit);
        bit trk;
        bit ev;
        trk = (t - last_trk) > DEAD;
        if (trk) begin
            last_trk = t;
            fwd_exp++;
        end
        for (int k = 0; k < pw; k++) sch_pre[t + k] = 1'b1;
        for (int k = 0; k < aw; k++) sch_acc[t + LAT + k] = 1'b1;
        if (vlat >= 0) begin
            sch_stb[t + vlat] = 1'b1;
            if (vbit) sch_bit[t + vlat] = 1'b1;
        end
        ev = trk && vlat >= VMIN && vlat <= VMAX && vbit;
        exp_t.push_back(t + LAT);
        exp_v.push_back(ev);
    endtask

    task automatic add_pre_only(input int t);
        if ((t - last_trk) > DEAD) begin
            last_trk = t;
            fwd_exp++;
        end
        sch_pre[t] = 1'b1;
    endtask

    task automatic add_orphan(input int t);
        sch_acc[t] = 1'b1;
        exp_t.push_back(t);
        exp_v.push_back(1'b0);
    endtask

    task automatic add_reset(input int t);
        sch_rst[t]     = 1'b1;
        sch_rst[t + 1] = 1'b1;
        last_trk       = -1000;
    endtask

    // monitor: pops the scoreboard on every forwarded accept
    always @(negedge clk) begin
        if (cyc > 3) begin
            if (pretrig_o) fwd_seen++;
            if (accept_o) begin
                if (exp_t.size() == 0) begin
                    check("R1 unexpected accept_o", accept_o, 1'b0);
                end else begin
                    int et;
                    bit ev;
                    et = exp_t.pop_front();
                    ev = exp_v.pop_front();
                    n_cmp++;
                    if (et != cyc) begin
                        n_bad++;
                        $display("FAIL R1 accept time actual=%0d expected=%0d", cyc, et);
                    end
                    check("R4/R5 veto_o at accept", veto_o, ev);
                end
            end
        end
    end

    task automatic at(input int c);
        while (cyc != c) @(negedge clk);
    endtask

    initial begin
        for (int k = 0; k <= 3; k++) sch_rst[k] = 1'b1;
        add_evt(100, 1, 1, 60, 1'b1);   // R4 lower end of window
        add_evt(130, 1, 1, 80, 1'b1);   // R4 upper end of window
        add_evt(160, 1, 1, 70, 1'b0);   // R5 decision bit 0
        add_evt(175, 1, 1, -1, 1'b0);   // R3 gap 15, ignored
        add_evt(179, 1, 1, -1, 1'b0);   // R3 gap 19, ignored
        add_evt(181, 5, 3, 65, 1'b1);   // R3 gap 21 tracked, R8 wide pulses
        add_evt(400, 1, 1, 59, 1'b1);   // R6 strobe one cycle early
        add_evt(419, 1, 1, -1, 1'b0);   // R3 gap 19, ignored
        add_evt(421, 1, 1, 75, 1'b1);   // R3 gap 21 tracked
        add_orphan(900);                // R7
        add_pre_only(1000);
        add_pre_only(1090);
        add_reset(1100);                // R9 with events in flight
        add_orphan(1300);               // slot of 1000 was discarded
        add_evt(1105, 1, 1, 60, 1'b1);  // dead window restarted

        at(3);
        check("R9 reset pretrig_o", pretrig_o, 1'b0);
        check("R9 reset accept_o", accept_o, 1'b0);
        check("R9 reset veto_o", veto_o, 1'b0);
        check("R9 reset late_o", late_o, 1'b0);
        check("R9 reset orphan_o", orphan_o, 1'b0);
        at(100);  check("R2 forward pulse", pretrig_o, 1'b1);
        at(101);  check("R2 single pulse", pretrig_o, 1'b0);
        at(176);  check("R3 ignored not forwarded", pretrig_o, 1'b0);
        at(181);  check("R3 gap 21 forwarded", pretrig_o, 1'b1);
        at(182);  check("R8 wide pulse forwarded once", pretrig_o, 1'b0);
        at(450);  check("R6 no late flag yet", late_o, 1'b0);
        at(465);  check("R6 early strobe flagged", late_o, 1'b1);
        at(899);  check("R7 no orphan yet", orphan_o, 1'b0);
        at(900);  check("R7 orphan flagged", orphan_o, 1'b1);
        at(1102);
        check("R9 reset clears orphan_o", orphan_o, 1'b0);
        check("R9 reset clears late_o", late_o, 1'b0);
        at(1105); check("R9 dead window cleared", pretrig_o, 1'b1);
        at(1300); check("R9 pending cleared, R7 orphan", orphan_o, 1'b1);
        at(1500);
        check("R6 in-window decision not late", late_o, 1'b0);
        n_cmp++;
        if (fwd_seen != fwd_exp) begin
            n_bad++;
            $display("FAIL R2/R3 forwarded count actual=%0d expected=%0d", fwd_seen, fwd_exp);
        end
        n_cmp++;
        if (exp_t.size() != 0) begin
            n_bad++;
            $display("FAIL R1 missing accepts actual=%0d expected=0", exp_t.size());
        end
        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        #(4 * 5000);
        if (!finished) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog cyc=%0d actual=running expected=done", cyc);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule